// File: doc/BRIEF.md
# Buck Regulator Soft-Start and Fault Sequencer

This block is the digital sequencer of a fixed-frequency synchronous buck controller. It runs from the system clock. It advances only on cycles where the oscillator tick input is high. It watches four comparator results: supply power-good, compensation-node enable, over-current and under-voltage. From them it produces a 7-bit reference code for the error-amplifier DAC, a gate-enable for the MOSFET drivers, and a 3-bit state code.

After both enables are seen, the sequencer waits through a fixed pre-delay. It then raises the reference in equal steps until it reaches the nominal regulation code, and then it regulates. An over-current event sends it back to the start of the pre-delay and holds it there while the fault lasts. An under-voltage event during regulation turns both gates off. That condition stays latched until the supply power-good goes away.

The comparator inputs are asynchronous, so each passes through a two-flop synchroniser. The oscillator tick is a synchronous clock enable and is used directly.

States and transitions (state code in brackets):
- OFF [0] goes to DELAY when both enables are high.
- DELAY [1] goes to RAMP after the pre-delay, and to OFF when an enable is lost. An over-current fault keeps it in DELAY with the count cleared.
- RAMP [2] goes to RUN when the code reaches its target, to DELAY on over-current, and to OFF when an enable is lost.
- RUN [3] goes to LATCHED on under-voltage, to DELAY on over-current, and to OFF when an enable is lost.
- LATCHED [4] goes to OFF when power-good falls.

Top module: `softstart_seq`

## Requirements
- R1: After reset the state is OFF (0), the code is 0 and gate-enable is 0. The block leaves OFF only when power-good and comp-enable are both high. When either one is low in DELAY, RAMP or RUN, the block returns to OFF.
- R2: In DELAY the code stays 0. The block moves to RAMP on the 2048th tick that follows entry to DELAY.
- R3: In RAMP the code goes up by exactly 1 after every 16 ticks, and never changes in any other way.
- R4: The code stops at 64. The block enters RUN on the same tick that brings the code to 64, which is 1024 ticks after RAMP begins. In RUN the code is 64.
- R5: Over-current seen in DELAY, RAMP or RUN sends the block to DELAY with the code at 0 and both counters cleared. While the fault remains, the block stays in DELAY at code 0. The full delay and ramp run again once the fault clears.
- R6: Under-voltage is ignored in DELAY and RAMP. In RUN it moves the block to LATCHED (4) with the code at 0 and gate-enable at 0. LATCHED ignores under-voltage, over-current and comp-enable, and is left only, to OFF, when power-good goes low.
- R7: Gate-enable is high only in RAMP and RUN. It goes low when comp-enable is deasserted.
- R8: A change on any comparator input takes effect on the third rising clock edge after the change. The first two edges fill the synchroniser.
- R9: When several conditions are present at once, loss of an enable wins over under-voltage, and under-voltage wins over over-current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period (synchronous) |
| pwr_good_i | input | 1 | Supply above its power-on threshold (asynchronous) |
| comp_ok_i | input | 1 | Compensation node above its shutdown threshold (asynchronous) |
| over_cur_i | input | 1 | Low-side current sense above its trip level (asynchronous) |
| under_volt_i | input | 1 | Feedback below half the reference (asynchronous) |
| ref_code_o | output | 7 | Reference DAC code, 12.5 mV per LSB |
| gate_en_o | output | 1 | Allows the gate drivers to switch |
| state_o | output | 3 | Sequencer state code: 0 OFF, 1 DELAY, 2 RAMP, 3 RUN, 4 LATCHED |

## Verification
The assertions assume that the comparator inputs reach the sequencer only through its synchronisers. They also assume that the oscillator tick is a synchronous enable, so ramp and delay progress is counted only on tick edges. The stimulus changes comparator inputs on falling clock edges. It varies the tick density at random with a fixed seed. It counts delivered ticks so that expected codes and states can be derived from tick counts alone. Directed cases cover over-current at each phase, under-voltage masking and latching, and inputs that arrive together.

// File: rtl/ss_pkg.sv
package ss_pkg;
    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_DELAY   = 3'd1,
        ST_RAMP    = 3'd2,
        ST_RUN     = 3'd3,
        ST_LATCHED = 3'd4
    } ss_state_e;

    localparam int SYNC_BITS = 4;
    localparam int IDX_PWR   = 0;
    localparam int IDX_COMP  = 1;
    localparam int IDX_OCP   = 2;
    localparam int IDX_UVP   = 3;
endpackage

// File: rtl/ss_sync_bank.sv
module ss_sync_bank #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            end
            assign sync_o[b] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/ss_delay_timer.sv
module ss_delay_timer #(
    parameter int DELAY_TICKS = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CW = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run_i) cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = run_i && tick_i && (cnt_q == LAST);
endmodule

// File: rtl/ss_ref_ramp.sv
module ss_ref_ramp #(
    parameter int CODE_W     = 7,
    parameter int STEP_TICKS = 16,
    parameter int TARGET     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              step_en_i,
    input  logic              tick_i,
    output logic [CODE_W-1:0] code_o,
    output logic              done_o
);
    localparam int SW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
    localparam logic [SW-1:0]     STEP_LAST = SW'(STEP_TICKS - 1);
    localparam logic [CODE_W-1:0] TGT       = CODE_W'(TARGET);
    localparam logic [CODE_W-1:0] TGT_M1    = CODE_W'(TARGET - 1);

    logic [SW-1:0]     step_q;
    logic [CODE_W-1:0] code_q;
    logic              step_wrap;

    assign step_wrap = step_en_i && tick_i && (step_q == STEP_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
            code_q <= '0;
        end else if (clr_i) begin
            step_q <= '0;
            code_q <= '0;
        end else if (step_en_i && tick_i) begin
            step_q <= step_wrap ? '0 : step_q + 1'b1;
            if (step_wrap && code_q != TGT) code_q <= code_q + 1'b1;
        end
    end

    assign code_o = code_q;
    assign done_o = step_wrap && (code_q == TGT_M1);

    // R4: the code never passes the target
    p_code_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        code_q <= TGT);

    // R3: the code moves only by a single up-step or a return to zero
    p_code_stride_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != $past(code_q)) |-> (code_q == '0 || code_q == $past(code_q) + 1'b1));
endmodule

// File: rtl/ss_seq_fsm.sv
module ss_seq_fsm
    import ss_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pwr_s,
    input  logic      comp_s,
    input  logic      ocp_s,
    input  logic      uvp_s,
    input  logic      delay_done_i,
    input  logic      ramp_done_i,
    output ss_state_e state_o,
    output logic      delay_run_o,
    output logic      ramp_clr_o,
    output logic      ramp_step_o,
    output logic      gate_en_o
);
    ss_state_e state_q, state_d;
    logic      en_s;

    assign en_s = pwr_s && comp_s;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:     if (en_s) state_d = ST_DELAY;
            ST_DELAY: begin
                if (!en_s)                      state_d = ST_OFF;
                else if (!ocp_s && delay_done_i) state_d = ST_RAMP;
            end
            ST_RAMP: begin
                if (!en_s)            state_d = ST_OFF;
                else if (ocp_s)       state_d = ST_DELAY;
                else if (ramp_done_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!en_s)      state_d = ST_OFF;
                else if (uvp_s) state_d = ST_LATCHED;
                else if (ocp_s) state_d = ST_DELAY;
            end
            ST_LATCHED: if (!pwr_s) state_d = ST_OFF;
            default:    state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        gate_en_o   = 1'b0;
        ramp_step_o = 1'b0;
        delay_run_o = 1'b0;
        unique case (state_q)
            ST_OFF, ST_LATCHED: ;
            ST_DELAY: delay_run_o = !ocp_s;
            ST_RAMP: begin
                gate_en_o   = 1'b1;
                ramp_step_o = 1'b1;
            end
            ST_RUN:   gate_en_o = 1'b1;
            default:  ;
        endcase
        ramp_clr_o = !(state_d == ST_RAMP || state_d == ST_RUN);
    end

    assign state_o = state_q;

    // R1 / R9: a lost enable always ends in OFF, or in LATCHED if already latched
    p_disable_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_s && state_q != ST_LATCHED) |=> (state_q == ST_OFF));

    // R5: over-current in an active state restarts at DELAY unless an enable loss or under-voltage in RUN wins
    p_ocp_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && ocp_s && (state_q == ST_DELAY || state_q == ST_RAMP ||
                           (state_q == ST_RUN && !uvp_s))) |=> (state_q == ST_DELAY));

    // R6: the latch holds while power-good stays high
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCHED && pwr_s) |=> (state_q == ST_LATCHED));

    // R6: under-voltage outside RUN never produces the latch
    p_uv_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP || state_q == ST_DELAY) |=> (state_q != ST_LATCHED));
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
    import ss_pkg::*;
#(
    parameter int CODE_W      = 7,
    parameter int DELAY_TICKS = 2048,
    parameter int STEP_TICKS  = 16,
    parameter int TARGET      = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              pwr_good_i,
    input  logic              comp_ok_i,
    input  logic              over_cur_i,
    input  logic              under_volt_i,
    output logic [CODE_W-1:0] ref_code_o,
    output logic              gate_en_o,
    output logic [2:0]        state_o
);
    localparam logic [CODE_W-1:0] TGT = CODE_W'(TARGET);

    logic [SYNC_BITS-1:0] raw_in, syn;
    logic      delay_run, delay_done, ramp_clr, ramp_step, ramp_done;
    ss_state_e st;

    assign raw_in[IDX_PWR]  = pwr_good_i;
    assign raw_in[IDX_COMP] = comp_ok_i;
    assign raw_in[IDX_OCP]  = over_cur_i;
    assign raw_in[IDX_UVP]  = under_volt_i;

    ss_sync_bank #(.WIDTH(SYNC_BITS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(syn));

    ss_delay_timer #(.DELAY_TICKS(DELAY_TICKS)) u_delay (
        .clk(clk), .rst_n(rst_n), .run_i(delay_run), .tick_i(osc_tick),
        .done_o(delay_done));

    ss_ref_ramp #(.CODE_W(CODE_W), .STEP_TICKS(STEP_TICKS), .TARGET(TARGET)) u_ramp (
        .clk(clk), .rst_n(rst_n), .clr_i(ramp_clr), .step_en_i(ramp_step),
        .tick_i(osc_tick), .code_o(ref_code_o), .done_o(ramp_done));

    ss_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .pwr_s(syn[IDX_PWR]), .comp_s(syn[IDX_COMP]),
        .ocp_s(syn[IDX_OCP]), .uvp_s(syn[IDX_UVP]),
        .delay_done_i(delay_done), .ramp_done_i(ramp_done),
        .state_o(st), .delay_run_o(delay_run), .ramp_clr_o(ramp_clr),
        .ramp_step_o(ramp_step), .gate_en_o(gate_en_o));

    assign state_o = st;

    // R2: reference is held at zero throughout the pre-delay
    p_delay_code_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DELAY) |-> (ref_code_o == '0));

    // R4: regulation always runs at the full target code
    p_run_full_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> (ref_code_o == TGT));

    // R7: gates switch only if both enables were present at the previous edge
    p_gate_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en_o |-> $past(syn[IDX_PWR] && syn[IDX_COMP]));
endmodule

// File: tb/tb_softstart_seq.sv
module tb_softstart_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       pwr_good_i = 1'b0, comp_ok_i = 1'b0, over_cur_i = 1'b0, under_volt_i = 1'b0;
    logic [6:0] ref_code_o;
    logic       gate_en_o;
    logic [2:0] state_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    softstart_seq dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .pwr_good_i(pwr_good_i), .comp_ok_i(comp_ok_i),
        .over_cur_i(over_cur_i), .under_volt_i(under_volt_i),
        .ref_code_o(ref_code_o), .gate_en_o(gate_en_o), .state_o(state_o));

    function automatic int exp_state(int t);
        if (t < 2048) return 1;
        if (t < 3072) return 2;
        return 3;
    endfunction

    function automatic int exp_code(int t);
        int c;
        if (t < 2048) return 0;
        c = (t - 2048) / 16;
        return (c > 64) ? 64 : c;
    endfunction

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic chk_all(string req, int st, int code, int gate);
        chk(req, state_o, st);
        chk(req, ref_code_o, code);
        chk(req, gate_en_o, gate);
    endtask

    // Counts delivered ticks from the moment the sequencer is in (or will enter) DELAY.
    task automatic run_seq(int lead, inout int t, input int t_stop, input int pct);
        string tag;
        int es;
        repeat (lead) @(posedge clk);
        if (lead > 0) @(negedge clk);
        while (t < t_stop) begin
            osc_tick = (($urandom % 100) < pct);
            @(posedge clk);
            if (osc_tick) t++;
            @(negedge clk);
            es  = exp_state(t);
            tag = (es == 1) ? "R2" : (es == 2) ? "R3" : "R4";
            chk(tag, state_o, es);
            chk(tag, ref_code_o, exp_code(t));
            chk("R7", gate_en_o, (es >= 2) ? 1 : 0);
        end
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_up(int pct, int t_stop, output int t);
        t = 0;
        pwr_good_i = 1'b1;
        comp_ok_i  = 1'b1;
        run_seq(3, t, t_stop, pct);
    endtask

    task automatic to_off_by_pwr();
        pwr_good_i = 1'b0;
        edges(3);
        chk_all("R1", 0, 0, 0);
    endtask

    task automatic ocp_hit(int hold, int pct, int t_stop);
        int t;
        over_cur_i = 1'b1;
        edges(3);
        chk_all("R5", 1, 0, 0);
        repeat (hold) begin
            osc_tick = (($urandom % 100) < pct);
            edges(1);
            chk("R5", state_o, 1);
            chk("R5", ref_code_o, 0);
        end
        over_cur_i = 1'b0;
        t = 0;
        run_seq(2, t, t_stop, pct);
    endtask

    initial begin
        int t;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_all("R1", 0, 0, 0);
        rst_n = 1'b1;
        edges(2);
        chk_all("R1", 0, 0, 0);

        // power-good alone does not start
        pwr_good_i = 1'b1;
        osc_tick = 1'b1;
        edges(20);
        chk_all("R1", 0, 0, 0);

        // synchroniser latency: two edges without effect, the third starts DELAY
        comp_ok_i = 1'b1;
        edges(2);
        chk("R8", state_o, 0);
        edges(1);
        chk("R8", state_o, 1);
        t = 0;
        run_seq(0, t, 3072 + 40, 100);

        // over-current in RUN, two edges of latency then restart
        over_cur_i = 1'b1;
        edges(2);
        chk("R8", state_o, 3);
        edges(1);
        chk_all("R5", 1, 0, 0);
        repeat (30 + ($urandom % 50)) begin
            edges(1);
            chk("R5", state_o, 1);
            chk("R5", ref_code_o, 0);
        end
        over_cur_i = 1'b0;
        t = 0;
        run_seq(2, t, 3072 + 20, 60);

        // comp disable acts as shutdown
        comp_ok_i = 1'b0;
        edges(3);
        chk_all("R7", 0, 0, 0);
        edges(10);
        chk_all("R1", 0, 0, 0);

        // over-current mid-ramp, short pulse
        start_up(100, 2048 + 300, t);
        chk("R3", ref_code_o, 18);
        ocp_hit(0, 100, 3072 + 10);

        // over-current during DELAY restarts the count
        to_off_by_pwr();
        start_up(100, 1500, t);
        ocp_hit(5, 75, 3072 + 10);

        // losing power-good mid-ramp
        to_off_by_pwr();
        start_up(80, 2600, t);
        to_off_by_pwr();

        // under-voltage masked during DELAY and RAMP
        under_volt_i = 1'b1;
        start_up(90, 2048 + 500, t);
        under_volt_i = 1'b0;
        run_seq(0, t, 3072 + 20, 90);

        // under-voltage in RUN latches off
        under_volt_i = 1'b1;
        edges(3);
        chk_all("R6", 4, 0, 0);
        under_volt_i = 1'b0;
        over_cur_i = 1'b1;
        comp_ok_i = 1'b0;
        edges(10);
        comp_ok_i = 1'b1;
        over_cur_i = 1'b0;
        edges(10);
        chk_all("R6", 4, 0, 0);
        to_off_by_pwr();

        // under-voltage beats over-current
        start_up(100, 3072 + 5, t);
        under_volt_i = 1'b1;
        over_cur_i = 1'b1;
        edges(3);
        chk_all("R9", 4, 0, 0);
        under_volt_i = 1'b0;
        over_cur_i = 1'b0;
        to_off_by_pwr();

        // enable loss beats both faults
        start_up(100, 3072 + 5, t);
        under_volt_i = 1'b1;
        over_cur_i = 1'b1;
        comp_ok_i = 1'b0;
        edges(3);
        chk_all("R9", 0, 0, 0);
        under_volt_i = 1'b0;
        over_cur_i = 1'b0;
        pwr_good_i = 1'b0;
        edges(3);

        // random tick density and fault placement
        for (int i = 0; i < 4; i++) begin
            int pct;
            pct = 50 + ($urandom % 51);
            start_up(pct, 200 + ($urandom % 2800), t);
            ocp_hit($urandom % 40, pct, 3072 + 8);
            to_off_by_pwr();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule